// File: doc/BRIEF.md
# Multichannel SAR Scan Controller

This block is the digital side of an eight-input, ten-bit successive-approximation converter. Software writes a channel mask and a control word. On a start request the block picks the lowest enabled channel and drives it on the mux select. It spends one clock sampling, then runs a ten-step binary search. In each step it presents a trial code to the external DAC and reads one comparator bit back.

Finished conversions land in result slots 0, 1, 2 and so on. Each slot can be read right-aligned or left-aligned. Enabled channels are visited in ascending order and wrap around, so a mask with fewer channels than the group size converts some channels more than once. After a group of four or eight conversions the block raises a sticky completion flag. The flag drives the interrupt output when the interrupt enable is set. The block then either stops or, in continuous mode, carries on with the next channel in the rotation, starting again at slot 0.

Top module: `sar_scan_ctrl`

## Requirements
- R1: After reset the interrupt output is 0, the DAC code is 0 and the mux select is 0, with the converter idle and the completion flag clear.
- R2: A conversion presents trial code 10'h200 to the DAC first. At each step it clears the trial bit when the comparator input is 0 (input below the DAC level) and keeps it when it is 1, then sets the next lower bit. With an ideal comparator that returns 1 when the input is at or above the DAC code, the stored result equals the input.
- R3: The mux select is held for the whole search. Enabled channels (mask bit n at register 1 enables channel n) are converted in ascending order, wrapping from the highest enabled channel to the lowest.
- R4: The k-th conversion of a group is stored in slot k. Reading address 8+k returns the result in bits [9:0] with the other bits 0. Reading address 16+k returns it in bits [15:6] with the other bits 0.
- R5: The control register is at address 0, with enable in bit 0, start in bit 1, continuous in bit 2, group-of-eight in bit 3 and interrupt enable in bit 4. The group is four conversions when bit 3 is 0 and eight when it is 1. Each conversion takes 11 clocks, so the completion flag is set at the 11·G-th rising edge after the edge that accepts the start.
- R6: The interrupt output is high exactly while the completion flag is set and the interrupt enable bit is 1.
- R7: The completion flag (address 2, bit 0) stays set until a write to address 2 with bit 0 equal to 1. A write with bit 0 equal to 0 leaves it set.
- R8: Outside continuous mode the block goes idle after a group, and the DAC code is 0 whenever the block is idle.
- R9: In continuous mode the scan goes on after a group without a new start. It restarts at slot 0 and continues the channel rotation from the channel after the last one converted.
- R10: A start request while a scan is running is ignored, and the running scan keeps its timing and results.
- R11: A start with an all-zero channel mask leaves the block idle and never sets the completion flag.
- R12: Writing the control register with enable 0 stops any scan at once. The DAC code returns to 0 and no further flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| mux_sel | output | 3 | Analog input mux select |
| dac_code | output | 10 | Trial code to the DAC, 0 when idle |
| comp_in | input | 1 | Comparator result, 1 when the input is at or above the DAC level |
| irq | output | 1 | Completion interrupt |

## Verification
The ideal comparator is stimulated with several masks, and each one separates a different failure:
- A contiguous mask of three channels inside a group of four forces a wrap and proves ascending order.
- A sparse mask with eight conversions catches slot-indexing and wrap errors past slot 3.
- A single-channel mask shows that repeats are handled.

The input values include 0, 1023, 511, 512 and odd codes, so that every trial bit is seen both kept and cleared.

Timing is pinned by counting the exact edge at which the interrupt rises, with a second start injected mid-scan. Continuous mode, the zero mask and disable are judged by whether the DAC goes quiet and the flag stays down.

// File: rtl/sar_scan_pkg.sv
package sar_scan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } scan_state_t;

  localparam int unsigned REG_AW = 5;

  localparam logic [REG_AW-1:0] ADR_CTRL = 5'd0;
  localparam logic [REG_AW-1:0] ADR_MASK = 5'd1;
  localparam logic [REG_AW-1:0] ADR_STAT = 5'd2;

  // control word bit positions
  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_GO   = 1;
  localparam int unsigned CB_CONT = 2;
  localparam int unsigned CB_GRP8 = 3;
  localparam int unsigned CB_IRQ  = 4;
  localparam int unsigned CB_BUSY = 5;

endpackage

// File: rtl/sar_chan_pick.sv
module sar_chan_pick #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CH_W   = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] mask,
  input  logic [CH_W-1:0]   cur,
  input  logic              restart,
  output logic [CH_W-1:0]   pick,
  output logic              any
);

  logic [CH_W-1:0] lowest;
  logic [CH_W-1:0] above;
  logic            found_above;

  // descending walk: the last hit is the lowest match
  always_comb begin
    lowest      = '0;
    above       = '0;
    found_above = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask[i]) begin
        lowest = CH_W'(i);
        if (i > int'(cur)) begin
          above       = CH_W'(i);
          found_above = 1'b1;
        end
      end
    end
  end

  assign any  = |mask;
  assign pick = (restart || !found_above) ? lowest : above;

endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int unsigned RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                abort,
  input  logic                comp_in,
  output logic [RES_BITS-1:0] dac_code,
  output logic [RES_BITS-1:0] result,
  output logic                last,
  output logic                active
);

  logic [RES_BITS-1:0] code_q, code_d;
  logic [RES_BITS-1:0] ptr_q, ptr_d;
  logic                act_q, act_d;
  logic [RES_BITS-1:0] kept;
  logic                upd_en;

  assign kept = comp_in ? code_q : (code_q & ~ptr_q);

  always_comb begin
    code_d = code_q;
    ptr_d  = ptr_q;
    act_d  = act_q;
    if (abort) begin
      code_d = '0;
      ptr_d  = '0;
      act_d  = 1'b0;
    end else if (start) begin
      ptr_d  = {1'b1, {(RES_BITS-1){1'b0}}};
      code_d = {1'b1, {(RES_BITS-1){1'b0}}};
      act_d  = 1'b1;
    end else if (act_q) begin
      ptr_d  = ptr_q >> 1;
      code_d = kept | (ptr_q >> 1);
      if (ptr_q[0]) act_d = 1'b0;
    end
  end

  assign upd_en = abort | start | act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ptr_q  <= '0;
      act_q  <= 1'b0;
    end else if (upd_en) begin
      code_q <= code_d;
      ptr_q  <= ptr_d;
      act_q  <= act_d;
    end
  end

  assign dac_code = act_q ? code_q : '0;
  assign result   = kept;
  assign last     = act_q & ptr_q[0];
  assign active   = act_q;

endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank #(
  parameter int unsigned RES_BITS  = 10,
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [SLOT_W-1:0]   wsel,
  input  logic [RES_BITS-1:0] wdata,
  input  logic [SLOT_W-1:0]   rsel,
  output logic [RES_BITS-1:0] rdata
);

  logic [RES_BITS-1:0] slot_q [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = we && (wsel == SLOT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (hit) begin
        slot_q[g] <= wdata;
      end
    end
  end

  assign rdata = slot_q[rsel];

endmodule

// File: rtl/sar_scan_ctrl.sv
module sar_scan_ctrl
  import sar_scan_pkg::*;
#(
  parameter int unsigned RES_BITS = 10,
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CH_W     = $clog2(NUM_CH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_AW-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [REG_AW-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic [CH_W-1:0]      mux_sel,
  output logic [RES_BITS-1:0]  dac_code,
  input  logic                 comp_in,
  output logic                 irq
);

  localparam int unsigned NUM_SLOTS = 8;
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS);
  localparam int unsigned PAD_W     = DATA_W - RES_BITS;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  // register writes
  logic wr_ctrl, wr_mask, wr_stat;
  assign wr_ctrl = wr_en && (wr_addr == ADR_CTRL);
  assign wr_mask = wr_en && (wr_addr == ADR_MASK);
  assign wr_stat = wr_en && (wr_addr == ADR_STAT);

  logic              en_q, cont_q, grp8_q, irqen_q;
  logic [NUM_CH-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q    <= 1'b0;
      cont_q  <= 1'b0;
      grp8_q  <= 1'b0;
      irqen_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q    <= wr_data[CB_EN];
      cont_q  <= wr_data[CB_CONT];
      grp8_q  <= wr_data[CB_GRP8];
      irqen_q <= wr_data[CB_IRQ];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mask_q <= '0;
    else if (wr_mask) mask_q <= wr_data[NUM_CH-1:0];
  end

  // scan sequencer state
  scan_state_t       state_q, state_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              flag_q, flag_d;

  logic                go_req, stop_req;
  logic                srch_start, srch_abort, srch_last, srch_active;
  logic [RES_BITS-1:0] srch_result;
  logic                bank_we;
  logic [CH_W-1:0]     pick_ch;
  logic                pick_any;
  logic [SLOT_W-1:0]   grp_last;
  logic                busy;

  assign go_req   = wr_ctrl && wr_data[CB_GO] && wr_data[CB_EN];
  assign stop_req = wr_ctrl && !wr_data[CB_EN];
  assign grp_last = grp8_q ? SLOT_W'(7) : SLOT_W'(3);
  assign busy     = (state_q != ST_IDLE);

  sar_chan_pick #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W)
  ) u_pick (
    .mask    (mask_q),
    .cur     (ch_q),
    .restart (state_q == ST_IDLE),
    .pick    (pick_ch),
    .any     (pick_any)
  );

  always_comb begin
    state_d    = state_q;
    ch_d       = ch_q;
    slot_d     = slot_q;
    flag_d     = flag_q;
    srch_start = 1'b0;
    srch_abort = 1'b0;
    bank_we    = 1'b0;

    if (wr_stat && wr_data[0]) flag_d = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (go_req && pick_any) begin
          state_d = ST_SAMPLE;
          ch_d    = pick_ch;
          slot_d  = '0;
        end
      end
      ST_SAMPLE: begin
        srch_start = 1'b1;
        state_d    = ST_CONV;
      end
      ST_CONV: begin
        if (srch_last) begin
          bank_we = 1'b1;
          ch_d    = pick_ch;
          if (slot_q == grp_last) begin
            flag_d  = 1'b1;
            slot_d  = '0;
            state_d = cont_q ? ST_SAMPLE : ST_IDLE;
          end else begin
            slot_d  = slot_q + SLOT_W'(1);
            state_d = ST_SAMPLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (stop_req) begin
      state_d    = ST_IDLE;
      srch_abort = 1'b1;
      srch_start = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      slot_q  <= '0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      slot_q  <= slot_d;
      flag_q  <= flag_d;
    end
  end

  sar_search #(
    .RES_BITS (RES_BITS)
  ) u_search (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (srch_start),
    .abort    (srch_abort),
    .comp_in  (comp_in),
    .dac_code (dac_code),
    .result   (srch_result),
    .last     (srch_last),
    .active   (srch_active)
  );

  logic [RES_BITS-1:0] bank_rdata;

  sar_result_bank #(
    .RES_BITS  (RES_BITS),
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W)
  ) u_bank (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (bank_we),
    .wsel  (slot_q),
    .wdata (srch_result),
    .rsel  (rd_addr[SLOT_W-1:0]),
    .rdata (bank_rdata)
  );

  // read port: slots at 8..15 right-aligned, 16..23 left-aligned
  always_comb begin
    rd_data = '0;
    if (rd_addr == ADR_CTRL) begin
      rd_data[CB_EN]   = en_q;
      rd_data[CB_CONT] = cont_q;
      rd_data[CB_GRP8] = grp8_q;
      rd_data[CB_IRQ]  = irqen_q;
      rd_data[CB_BUSY] = busy;
    end else if (rd_addr == ADR_MASK) begin
      rd_data[NUM_CH-1:0] = mask_q;
    end else if (rd_addr == ADR_STAT) begin
      rd_data[0] = flag_q;
    end else if (rd_addr[REG_AW-1:SLOT_W] == 2'b01) begin
      rd_data = {{PAD_W{1'b0}}, bank_rdata};
    end else if (rd_addr[REG_AW-1:SLOT_W] == 2'b10) begin
      rd_data = {bank_rdata, {PAD_W{1'b0}}};
    end
  end

  assign mux_sel = ch_q;
  assign irq     = flag_q & irqen_q;

endmodule

// File: rtl/sar_scan_chk.sv
module sar_scan_chk
  import sar_scan_pkg::*;
#(
  parameter int unsigned RES_BITS = 10,
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CH_W     = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic [RES_BITS-1:0] dac_code,
  input logic                flag_q,
  input logic                wr_en,
  input logic [REG_AW-1:0]   wr_addr,
  input logic [DATA_W-1:0]   wr_data,
  input logic [CH_W-1:0]     mux_sel,
  input logic                srch_active,
  input logic                srch_last,
  input logic [NUM_CH-1:0]   mask_q
);

  logic ctrl_wr, clr_wr;
  assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL);
  assign clr_wr  = wr_en && (wr_addr == ADR_STAT) && wr_data[0];

  // R8
  idle_dac_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dac_code == '0));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_wr) |=> flag_q);

  // R3
  mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_active && $past(srch_active)) |-> $stable(mux_sel));

  // R11
  zero_mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctrl_wr && wr_data[CB_GO] && (mask_q == '0)) |=> !busy);

  // R12
  stop_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wr_data[CB_EN]) |=> (!busy && dac_code == '0));

  // R10
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_active && !srch_last && ctrl_wr && wr_data[CB_EN] && wr_data[CB_GO])
      |=> srch_active);

endmodule

bind sar_scan_ctrl sar_scan_chk #(
  .RES_BITS (RES_BITS),
  .NUM_CH   (NUM_CH),
  .DATA_W   (DATA_W),
  .CH_W     (CH_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .busy        (busy),
  .dac_code    (dac_code),
  .flag_q      (flag_q),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .mux_sel     (mux_sel),
  .srch_active (srch_active),
  .srch_last   (srch_last),
  .mask_q      (mask_q)
);

// File: tb/tb_sar_scan_ctrl.sv
`timescale 1ns/100ps
module tb_sar_scan_ctrl;
  import sar_scan_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [15:0] wr_data;
  logic [4:0]  rd_addr;
  logic [15:0] rd_data;
  logic [2:0]  mux_sel;
  logic [9:0]  dac_code;
  logic        comp_in;
  logic        irq;

  logic [9:0]  vin [8];

  always #2.5 clk = ~clk;

  // ideal comparator: 1 when the selected input is at or above the DAC level
  assign comp_in = (vin[mux_sel] >= dac_code);

  sar_scan_ctrl dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .mux_sel  (mux_sel),
    .dac_code (dac_code),
    .comp_in  (comp_in),
    .irq      (irq)
  );

  typedef struct {
    int         slot;
    logic [9:0] val;
  } exp_t;

  exp_t q[$];
  int errors = 0;
  int checks = 0;

  localparam logic [15:0] C_EN   = 16'h0001;
  localparam logic [15:0] C_GO   = 16'h0002;
  localparam logic [15:0] C_CONT = 16'h0004;
  localparam logic [15:0] C_GRP8 = 16'h0008;
  localparam logic [15:0] C_IRQ  = 16'h0010;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // driver side of the scoreboard: expected slot contents of one group
  task automatic push_group(input logic [7:0] m, input int n, inout int ch);
    int c;
    for (int k = 0; k < n; k++) begin
      c = 0;
      for (int s = 1; s <= 8; s++) begin
        c = (ch + s + 8) % 8;
        if (m[c]) break;
      end
      ch = c;
      q.push_back('{k, vin[c]});
    end
  endtask

  task automatic wait_drain(input string req, output bit irq_seen);
    int t = 0;
    irq_seen = 1'b0;
    while (q.size() > 0 && t < 3000) begin
      @(negedge clk);
      if (irq) irq_seen = 1'b1;
      t++;
    end
    chk(q.size() == 0, req, "group completed", q.size(), 0);
  endtask

  // monitor: on a set completion flag, read each expected slot in both views
  initial begin
    exp_t e;
    rd_addr = ADR_STAT;
    forever begin
      @(negedge clk);
      rd_addr = ADR_STAT;
      #0.5;
      if (rd_data[0] && q.size() > 0) begin
        while (q.size() > 0) begin
          e = q.pop_front();
          rd_addr = 5'(8 + e.slot);
          #0.2;
          chk(rd_data == {6'b0, e.val}, "R2 R3 R4", "right-aligned slot",
              int'(rd_data), int'({6'b0, e.val}));
          rd_addr = 5'(16 + e.slot);
          #0.2;
          chk(rd_data == {e.val, 6'b0}, "R4", "left-aligned slot",
              int'(rd_data), int'({e.val, 6'b0}));
        end
      end
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    int  ch;
    bit  bad;
    bit  seen;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    vin[0] = 10'd100; vin[1] = 10'd513; vin[2] = 10'd0;   vin[3] = 10'd1023;
    vin[4] = 10'd7;   vin[5] = 10'd300; vin[6] = 10'd512; vin[7] = 10'd511;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
    chk(dac_code == 10'd0, "R1", "dac after reset", dac_code, 0);
    chk(mux_sel == 3'd0, "R1", "mux after reset", mux_sel, 0);

    // group of four over channels 1,2,3 with a wrap; exact edge of completion
    wr(ADR_MASK, 16'h000E);
    ch = -1;
    push_group(8'h0E, 4, ch);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADR_CTRL; wr_data = C_EN | C_GO | C_IRQ;
    @(negedge clk);                      // after edge 0 (start accepted)
    wr_en = 1'b0;
    chk(mux_sel == 3'd1, "R3", "first channel selected", mux_sel, 1);
    @(negedge clk);                      // after edge 1
    chk(dac_code == 10'h200, "R2", "first trial code", dac_code, 10'h200);
    bad = 1'b0;
    for (int k = 2; k <= 43; k++) begin
      @(negedge clk);
      if (k == 20) begin                 // R10: second start mid-scan
        wr_en = 1'b1; wr_addr = ADR_CTRL; wr_data = C_EN | C_GO | C_IRQ;
      end else begin
        wr_en = 1'b0;
      end
      if (irq) bad = 1'b1;
    end
    chk(!bad, "R5 R10", "irq early", bad, 0);
    @(negedge clk);                      // after edge 44
    chk(irq == 1'b1, "R5 R6", "irq at 44th edge", irq, 1);
    wait_drain("R4", seen);
    bad = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (dac_code != 10'd0) bad = 1'b1;
    end
    chk(!bad, "R8", "dac quiet after single group", bad, 0);
    wr(ADR_STAT, 16'h0001);
    chk(irq == 1'b0, "R7", "flag cleared by writing 1", irq, 0);

    // group of eight on a sparse mask with interrupt disabled
    vin[0] = 10'd1023; vin[2] = 10'd900; vin[5] = 10'd640; vin[7] = 10'd999;
    wr(ADR_MASK, 16'h00A5);
    ch = -1;
    push_group(8'hA5, 8, ch);
    wr(ADR_CTRL, C_EN | C_GO | C_GRP8);
    wait_drain("R5", seen);
    chk(!seen, "R6", "irq masked while disabled", seen, 0);
    wr(ADR_STAT, 16'h0000);
    wr(ADR_CTRL, C_EN | C_GRP8 | C_IRQ);
    chk(irq == 1'b1, "R7", "flag kept after writing 0", irq, 1);
    wr(ADR_STAT, 16'h0001);
    chk(irq == 1'b0, "R7", "flag cleared", irq, 0);

    // single channel repeated four times, extreme code
    vin[4] = 10'd1023;
    wr(ADR_MASK, 16'h0010);
    ch = -1;
    push_group(8'h10, 4, ch);
    wr(ADR_CTRL, C_EN | C_GO | C_IRQ);
    wait_drain("R3", seen);
    wr(ADR_STAT, 16'h0001);

    // R11: start with empty mask
    wr(ADR_MASK, 16'h0000);
    wr(ADR_CTRL, C_EN | C_GO | C_IRQ);
    bad = 1'b0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (irq || dac_code != 10'd0) bad = 1'b1;
    end
    chk(!bad, "R11", "empty mask stays idle", bad, 0);

    // R9 continuous: second group continues the rotation without a new start
    for (int i = 0; i < 8; i++) vin[i] = 10'(37 * i + 200);
    wr(ADR_MASK, 16'h00FF);
    ch = -1;
    push_group(8'hFF, 4, ch);
    wr(ADR_CTRL, C_EN | C_GO | C_CONT | C_IRQ);
    wait_drain("R9", seen);
    wr(ADR_STAT, 16'h0001);
    push_group(8'hFF, 4, ch);
    wait_drain("R9", seen);
    chk(seen, "R9", "second group interrupt", seen, 1);
    wr(ADR_STAT, 16'h0001);

    // R12: disable stops the running scan
    wr(ADR_CTRL, C_IRQ);
    bad = 1'b0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (irq || dac_code != 10'd0) bad = 1'b1;
    end
    chk(!bad, "R12", "disable stops scan", bad, 0);

    report();
  end

endmodule